// File: doc/BRIEF.md
# Motor PWM Command Generator

This block turns a signed speed command into the three logic-level control lines of a full-bridge motor driver: a pulse line, a direction line and a brake line. A free-running period counter defines the switching frame. At each frame boundary the block takes a fresh snapshot of the command, the encoding mode, the brake request and the frame length. During the frame that follows, it produces the waveform that this snapshot describes.

Two encodings are offered. In anti-phase mode, the pulse line is held high and a single waveform is placed on the direction line. A 50% high time means no drive, and the offset from 50% carries both the sign and the size of the command. In sign/magnitude mode, the direction line carries the sign and the pulse line carries the magnitude as a high time. A zero command keeps the pulse line low for the whole frame. A brake request holds both the brake and pulse lines high and leaves the direction line where it was.

The bridge needs quiet time between edges on its control lines, so every output edge passes through a spacing gate. Two edges on the three lines are never closer than a parameterised number of clock cycles. When an edge arrives too early it is held back until the gap has elapsed; it is not discarded. When several lines must change, direction changes first, then brake, then the pulse line. As a result, a sign reversal always moves the direction line at least one spacing interval before the pulse line comes back.

Top module: `motor_pwm_gen`

## Requirements
- R1: While rst_n is low, pwm_o, dir_o and brake_o are all 0.
- R2: The frame is period_i+1 clock cycles long. The position within it runs from 0 up to the frame length value latched at the previous boundary, and then wraps to 0. The first frame after reset is one cycle long.
- R3: cmd_i, mode_i, brake_i and period_i are sampled only in the last cycle of a frame. A change at any other time has no effect on the outputs until the next frame.
- R4: In anti-phase mode (mode_i = 0), the pulse target is 1. The direction target is 1 while the frame position is below h = floor(P/2) + cmd, where P is the frame length, and 0 after that. A zero command gives 50% duty.
- R5: In sign/magnitude mode (mode_i = 1), the direction target is 1 for cmd ≥ 0 and 0 for cmd < 0. The pulse target is 1 while the frame position is below |cmd|. A zero command keeps pulse low for the whole frame.
- R6: A high time that falls outside 0..P is clamped. The result is 0% or 100% duty.
- R7: With a latched brake request, the brake and pulse targets are 1 and the direction target keeps the current direction output.
- R8: Any two output edges, on the same line or on different lines, are at least MIN_GAP cycles apart, and at most one line changes in any one cycle.
- R9: A line whose target differs from its output changes on the first cycle the gap allows. When several lines differ, the order is direction, then brake, then pulse.
- R10: Outputs are registered. A target formed at frame position c shows on the pins one clock later, provided the spacing gate allows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| mode_i | input | 1 | Encoding: 0 anti-phase, 1 sign/magnitude |
| cmd_i | input | CMD_W | Signed two's-complement speed command, in counts of high time |
| brake_i | input | 1 | Brake request |
| period_i | input | CNT_W | Frame length minus one, in clock cycles |
| pwm_o | output | 1 | Pulse control line |
| dir_o | output | 1 | Direction control line |
| brake_o | output | 1 | Brake control line |

## Verification
The assertions expect rst_n to fall and rise in step with the clock, so the checker's own edge history and the output registers leave reset on the same cycle. Because they test spacing and single-line change against the pins and against that history only, they hold for any sequence of commands, modes or frame lengths. The stimulus changes every input just after a falling clock edge. It covers fixed directed values and random values, with random values also changing in the middle of a frame. Frame lengths go down to one cycle, which keeps the gate busy with deferred edges.

// File: rtl/mpg_pkg.sv
package mpg_pkg;
  typedef enum logic {
    MODE_ANTI = 1'b0,
    MODE_SM   = 1'b1
  } drive_mode_e;

  // Bit positions of the control lines; lower index wins when edges compete.
  localparam int LINE_DIR = 0;
  localparam int LINE_BRK = 1;
  localparam int LINE_PWM = 2;
  localparam int NLINES   = 3;
endpackage

// File: rtl/mpg_frame.sv
module mpg_frame
  import mpg_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CMD_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_i,
  input  logic signed [CMD_W-1:0] cmd_i,
  input  logic                    brake_i,
  input  logic [CNT_W-1:0]        period_i,
  output logic [CNT_W-1:0]        cnt_o,
  output logic [CNT_W-1:0]        per_o,
  output logic signed [CMD_W-1:0] cmd_o,
  output drive_mode_e             mode_o,
  output logic                    brk_o,
  output logic                    wrap_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0]        cnt_q, cnt_d, per_q, per_d;
  logic signed [CMD_W-1:0] cmd_q, cmd_d;
  drive_mode_e             mode_q, mode_d;
  logic                    brk_q, brk_d;
  logic                    wrap;

  assign wrap = (cnt_q == per_q);

  // Next state: snapshot only at the frame boundary.
  always_comb begin
    cnt_d  = cnt_q + CNT_ONE;
    per_d  = per_q;
    cmd_d  = cmd_q;
    mode_d = mode_q;
    brk_d  = brk_q;
    if (wrap) begin
      cnt_d  = '0;
      per_d  = period_i;
      cmd_d  = cmd_i;
      mode_d = drive_mode_e'(mode_i);
      brk_d  = brake_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '0;
      cmd_q  <= '0;
      mode_q <= MODE_ANTI;
      brk_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      cmd_q  <= cmd_d;
      mode_q <= mode_d;
      brk_q  <= brk_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign per_o  = per_q;
  assign cmd_o  = cmd_q;
  assign mode_o = mode_q;
  assign brk_o  = brk_q;
  assign wrap_o = wrap;
endmodule

// File: rtl/mpg_duty.sv
module mpg_duty
  import mpg_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CMD_W = 8
) (
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [CNT_W-1:0]        per_i,
  input  logic signed [CMD_W-1:0] cmd_i,
  input  drive_mode_e             mode_i,
  input  logic                    brk_i,
  input  logic                    dir_hold_i,
  output logic [NLINES-1:0]       tgt_o
);
  // Wide enough for frame length, command and their sum without overflow.
  localparam int SW = ((CNT_W > CMD_W) ? CNT_W : CMD_W) + 3;
  localparam logic signed [SW-1:0] ONE  = 1;
  localparam logic signed [SW-1:0] ZERO = 0;

  logic signed [SW-1:0] len_s, pos_s, cmd_s, ap_raw, ap_h, mag_raw, sm_h;
  logic                 ap_on, sm_on;

  assign len_s = $signed({{(SW-CNT_W){1'b0}}, per_i}) + ONE;
  assign pos_s = $signed({{(SW-CNT_W){1'b0}}, cnt_i});
  assign cmd_s = $signed({{(SW-CMD_W){cmd_i[CMD_W-1]}}, cmd_i});

  // Anti-phase: centre on half the frame, offset by the command, clamp.
  always_comb begin
    ap_raw = (len_s >>> 1) + cmd_s;
    if (ap_raw < ZERO)       ap_h = ZERO;
    else if (ap_raw > len_s) ap_h = len_s;
    else                     ap_h = ap_raw;
  end

  // Sign/magnitude: magnitude of the command, clamped to a full frame.
  always_comb begin
    mag_raw = (cmd_s < ZERO) ? -cmd_s : cmd_s;
    sm_h    = (mag_raw > len_s) ? len_s : mag_raw;
  end

  assign ap_on = (pos_s < ap_h);
  assign sm_on = (pos_s < sm_h);

  always_comb begin
    tgt_o = '0;
    if (brk_i) begin
      tgt_o[LINE_PWM] = 1'b1;
      tgt_o[LINE_BRK] = 1'b1;
      tgt_o[LINE_DIR] = dir_hold_i;
    end else if (mode_i == MODE_SM) begin
      tgt_o[LINE_PWM] = sm_on;
      tgt_o[LINE_DIR] = ~cmd_i[CMD_W-1];
    end else begin
      tgt_o[LINE_PWM] = 1'b1;
      tgt_o[LINE_DIR] = ap_on;
    end
  end
endmodule

// File: rtl/mpg_spacer.sv
module mpg_spacer #(
  parameter int NL      = 3,
  parameter int MIN_GAP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] tgt_i,
  output logic [NL-1:0] out_o
);
  localparam int              GAP_W   = (MIN_GAP > 1) ? $clog2(MIN_GAP) : 1;
  localparam logic [GAP_W-1:0] GAP_TOP = GAP_W'(MIN_GAP - 1);
  localparam logic [GAP_W-1:0] GAP_ONE = GAP_W'(1);

  logic [NL-1:0]    out_q, out_d, diff, pick;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             ready, upd;
  logic [NL:0]      seen;

  assign diff  = tgt_i ^ out_q;
  assign ready = (gap_q >= GAP_TOP);
  assign upd   = ready && (|diff);

  // Lowest-index differing line wins the slot.
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NL; i++) begin : g_pick
    assign pick[i]   = diff[i] & ~seen[i];
    assign seen[i+1] = seen[i] | diff[i];
  end

  always_comb begin
    out_d = out_q;
    gap_d = gap_q;
    if (upd) begin
      out_d = out_q ^ pick;
      gap_d = '0;
    end else if (!ready) begin
      gap_d = gap_q + GAP_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      gap_q <= GAP_TOP;
    end else begin
      out_q <= out_d;
      gap_q <= gap_d;
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/motor_pwm_gen.sv
module motor_pwm_gen
  import mpg_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int CMD_W   = 8,
  parameter int MIN_GAP = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_i,
  input  logic signed [CMD_W-1:0] cmd_i,
  input  logic                    brake_i,
  input  logic [CNT_W-1:0]        period_i,
  output logic                    pwm_o,
  output logic                    dir_o,
  output logic                    brake_o
);
  logic [CNT_W-1:0]        cnt_q, per_q;
  logic signed [CMD_W-1:0] cmd_q;
  drive_mode_e             mode_q;
  logic                    brk_q, wrap;
  logic [NLINES-1:0]       tgt, outs;

  mpg_frame #(.CNT_W(CNT_W), .CMD_W(CMD_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cmd_i(cmd_i),
    .brake_i(brake_i), .period_i(period_i),
    .cnt_o(cnt_q), .per_o(per_q), .cmd_o(cmd_q), .mode_o(mode_q),
    .brk_o(brk_q), .wrap_o(wrap)
  );

  mpg_duty #(.CNT_W(CNT_W), .CMD_W(CMD_W)) u_duty (
    .cnt_i(cnt_q), .per_i(per_q), .cmd_i(cmd_q), .mode_i(mode_q),
    .brk_i(brk_q), .dir_hold_i(outs[LINE_DIR]), .tgt_o(tgt)
  );

  mpg_spacer #(.NL(NLINES), .MIN_GAP(MIN_GAP)) u_space (
    .clk(clk), .rst_n(rst_n), .tgt_i(tgt), .out_o(outs)
  );

  assign pwm_o   = outs[LINE_PWM];
  assign dir_o   = outs[LINE_DIR];
  assign brake_o = outs[LINE_BRK];
endmodule

// File: rtl/mpg_checker.sv
module mpg_checker #(
  parameter int CNT_W   = 8,
  parameter int CMD_W   = 8,
  parameter int MIN_GAP = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [CNT_W-1:0]        cnt_i,
  input logic [CNT_W-1:0]        per_i,
  input logic                    wrap_i,
  input logic signed [CMD_W-1:0] cmd_i,
  input logic [2:0]              outs_i
);
  localparam int              GW   = (MIN_GAP > 1) ? $clog2(MIN_GAP) : 1;
  localparam logic [GW-1:0]   GTOP = GW'(MIN_GAP - 1);

  logic [2:0]    prev_q;
  logic [GW-1:0] since_q;
  logic          chg;

  assign chg = (outs_i != prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      since_q <= GTOP;
    end else begin
      prev_q <= outs_i;
      if (chg)                since_q <= '0;
      else if (since_q < GTOP) since_q <= since_q + GW'(1);
    end
  end

  p_pos_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_i <= per_i);

  p_hold_mid_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> ($stable(cmd_i) && $stable(per_i)));

  p_single_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(outs_i ^ prev_q) <= 1);

  p_edge_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> (since_q >= GTOP));
endmodule

bind motor_pwm_gen mpg_checker #(.CNT_W(CNT_W), .CMD_W(CMD_W), .MIN_GAP(MIN_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_i(cnt_q), .per_i(per_q), .wrap_i(wrap),
  .cmd_i(cmd_q), .outs_i({pwm_o, brake_o, dir_o})
);

// File: tb/sim_motor_pwm_gen.sv
module sim_motor_pwm_gen;
  localparam int CNT_W   = 8;
  localparam int CMD_W   = 8;
  localparam int MIN_GAP = 4;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    mode_i;
  logic signed [CMD_W-1:0] cmd_i;
  logic                    brake_i;
  logic [CNT_W-1:0]        period_i;
  logic                    pwm_o, dir_o, brake_o;

  motor_pwm_gen #(.CNT_W(CNT_W), .CMD_W(CMD_W), .MIN_GAP(MIN_GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cmd_i(cmd_i),
    .brake_i(brake_i), .period_i(period_i),
    .pwm_o(pwm_o), .dir_o(dir_o), .brake_o(brake_o)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Reference state, built from the requirements: {pwm, brake, dir}.
  int       m_cnt, m_per, m_cmd, m_gap;
  bit       m_mode, m_brk;
  bit [2:0] m_out;
  // Independent spacing monitor on the pins.
  bit [2:0] last_pins;
  int       cyc_no, last_edge;
  int       n_pwm_hi, n_dir_hi;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc_no);
    end
  endtask

  task automatic step_model(bit md, int c, bit bk, int pr);
    int p, h;
    bit [2:0] tgt, diff;
    p = m_per + 1;
    if (m_brk) tgt = {1'b1, 1'b1, m_out[0]};
    else if (!m_mode) begin
      h = p / 2 + m_cmd;
      if (h < 0) h = 0;
      if (h > p) h = p;
      tgt = {1'b1, 1'b0, bit'(m_cnt < h)};
    end else begin
      h = (m_cmd < 0) ? -m_cmd : m_cmd;
      if (h > p) h = p;
      tgt = {bit'(m_cnt < h), 1'b0, bit'(m_cmd >= 0)};
    end
    diff = tgt ^ m_out;
    if (m_gap >= MIN_GAP - 1 && diff != 3'b000) begin
      if (diff[0])      m_out[0] = ~m_out[0];
      else if (diff[1]) m_out[1] = ~m_out[1];
      else              m_out[2] = ~m_out[2];
      m_gap = 0;
    end else if (m_gap < MIN_GAP - 1) m_gap++;
    if (m_cnt == m_per) begin
      m_cnt = 0; m_per = pr; m_cmd = c; m_mode = md; m_brk = bk;
    end else m_cnt++;
  endtask

  // One clock: compare at the falling edge, drive, advance the reference.
  task automatic cyc(string req, bit md, int c, bit bk, int pr);
    bit [2:0] pins;
    @(negedge clk);
    cyc_no++;
    pins = {pwm_o, brake_o, dir_o};
    check(req, int'(pins), int'(m_out));
    if (pins != last_pins) begin
      check("R8", int'(cyc_no - last_edge >= MIN_GAP), 1);
      check("R8", $countones(pins ^ last_pins), 1);
      last_edge = cyc_no;
    end
    last_pins = pins;
    n_pwm_hi += int'(pwm_o);
    n_dir_hi += int'(dir_o);
    mode_i = md; cmd_i = CMD_W'(c); brake_i = bk; period_i = CNT_W'(pr);
    step_model(md, c, bk, pr);
  endtask

  task automatic run(string req, bit md, int c, bit bk, int pr, int n);
    for (int i = 0; i < n; i++) cyc(req, md, c, bk, pr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; mode_i = 1'b0; cmd_i = '0; brake_i = 1'b0; period_i = '0;
    m_cnt = 0; m_per = 0; m_cmd = 0; m_gap = MIN_GAP - 1;
    m_mode = 1'b0; m_brk = 1'b0; m_out = 3'b000;
    last_pins = 3'b000; cyc_no = 0; last_edge = -100;
    repeat (3) begin
      @(negedge clk);
      check("R1", int'({pwm_o, brake_o, dir_o}), 0);
    end
    rst_n = 1'b1;
    step_model(1'b0, 0, 1'b0, 19);
    period_i = 8'd19;

    // R4: anti-phase, zero command then small offsets of both signs.
    run("R4", 1'b0, 0, 1'b0, 19, 60);
    n_dir_hi = 0; n_pwm_hi = 0;
    run("R4", 1'b0, 0, 1'b0, 19, 40);
    check("R4", n_dir_hi, 20);
    check("R4", n_pwm_hi, 40);
    run("R4", 1'b0, 5, 1'b0, 19, 60);
    run("R4", 1'b0, -7, 1'b0, 19, 60);

    // R5: sign/magnitude, zero command keeps the pulse line low.
    run("R5", 1'b1, 0, 1'b0, 15, 64);
    n_pwm_hi = 0;
    run("R5", 1'b1, 0, 1'b0, 15, 48);
    check("R5", n_pwm_hi, 0);
    run("R5", 1'b1, 9, 1'b0, 15, 64);

    // R9: sign reversal; direction moves before the pulse line returns.
    run("R9", 1'b1, -9, 1'b0, 15, 64);
    run("R9", 1'b1, 3, 1'b0, 1, 40);

    // R6: saturation in both modes.
    run("R6", 1'b1, 127, 1'b0, 9, 40);
    n_pwm_hi = 0;
    run("R6", 1'b1, 127, 1'b0, 9, 40);
    check("R6", n_pwm_hi, 40);
    run("R6", 1'b0, -128, 1'b0, 9, 40);
    n_dir_hi = 0;
    run("R6", 1'b0, -128, 1'b0, 9, 40);
    check("R6", n_dir_hi, 0);

    // R7: brake from sign/magnitude and from anti-phase.
    run("R7", 1'b1, -20, 1'b0, 11, 36);
    run("R7", 1'b1, -20, 1'b1, 11, 36);
    check("R7", int'({pwm_o, brake_o}), 3);
    run("R7", 1'b0, 4, 1'b1, 11, 36);
    run("R7", 1'b0, 4, 1'b0, 11, 36);

    // R2: frame length changes, down to single-cycle frames.
    run("R2", 1'b0, 1, 1'b0, 0, 20);
    run("R2", 1'b0, 2, 1'b0, 37, 80);

    // R3: inputs change every cycle, only boundaries count.
    for (int i = 0; i < 600; i++)
      cyc("R3", 1'($urandom_range(0, 1)), int'($urandom_range(0, 60)) - 30,
          1'($urandom_range(0, 15) == 0), 25);

    // R10: random blocks of steady inputs.
    for (int b = 0; b < 40; b++) begin
      int pr, c;
      bit md, bk;
      pr = int'($urandom_range(1, 40));
      c  = int'($urandom_range(0, 255)) - 128;
      md = 1'($urandom_range(0, 1));
      bk = 1'($urandom_range(0, 7) == 0);
      run("R10", md, c, bk, pr, (pr + 1) * 3);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule